// File: doc/BRIEF.md
# Serial Flash Single-Byte Access Sequencer

This block lets a host reach individual bytes of a serial NOR flash through a small byte-wide register port. The host loads a 32-bit byte address, a lane/width mode byte, a timing byte and two read-opcode bytes. It then writes a command byte. The sequencer drives one complete flash frame on the serial pins. A read frame sends an opcode, the address and optional dummy clocks, then captures one byte into a read-data register. A write frame sends a fixed program opcode, the address, and one byte taken from a write-data register.

The command register reports a busy flag for the command in progress, and the host polls it. Every completed command advances the stored address by one. Back-to-back commands therefore walk through consecutive flash bytes without the address being rewritten. Read frames may carry the address and the data on one, two or four lanes, set by the mode byte. Write frames always use a single lane.

Top module: `sfl_byte_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_io_oe` is 0. Every register reads 0. Whenever `spi_cs_n` is high, `spi_sclk` is low and no lane is enabled.
- R2: The address bytes sit at offsets 0x08 (bits 7:0), 0x09 (bits 15:8) and 0x0A (bits 23:16). The top byte (bits 31:24) sits apart, at 0x1C. Read opcode A is at 0x10 and read opcode B at 0x11. The timing byte is at 0x14, the mode byte at 0x18 and the write data at 0x0C. Each of these reads back what was written.
- R3: Writing 0x81 to offset 0x00 starts a read, and bit 0 of offset 0x00 reads 1 until the read completes. Writing 0x90 starts a write, and bit 4 reads 1 until the write completes. Any other command value is ignored: no frame is sent and the register reads 0.
- R4: Each frame begins with 8 opcode clocks on lane 0, most significant bit first, with `spi_io_oe` = 0001. A read uses opcode B when mode bit 2 is set, and opcode A otherwise. A write uses the opcode 0x02.
- R5: When mode bit 4 is set the full 32-bit address is sent. Otherwise only bits 23:0 are sent. In both cases the most significant bit goes first.
- R6: For reads, the address is sent on 4 lanes if mode bit 3 is set, otherwise on 2 lanes if mode bit 1 is set, otherwise on 1 lane. On each clock the highest enabled lane carries the more significant bit, and `spi_io_oe` enables exactly the lanes in use. Writes always send the address on 1 lane.
- R7: For reads, timing-byte bit 0 adds 8 dummy clocks after the address, with all lanes released. Writes never get dummy clocks.
- R8: Read data arrives on 4 lanes if mode bit 2 is set, otherwise on 2 lanes (io[1:0]) if mode bit 0 is set, otherwise on io[1] alone. It is taken most significant bit first, with no lane enabled. The captured byte reads back at offset 0x04.
- R9: A write sends the byte at offset 0x0C on lane 0 over 8 clocks, most significant bit first, directly after the address.
- R10: Each completed command adds 1 to the 32-bit address, wrapping from 0xFFFFFFFF to 0. A following command with no address rewrite uses the incremented address.
- R11: While a command is busy, host writes to every offset, including new commands, are ignored.
- R12: A frame runs only while `spi_cs_n` is low. Each serial clock is one system clock low, then one high. Lane outputs change only while `spi_sclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_out | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_in | input | 4 | Lane input values |

## Verification
The assertions assume that the host never drives a frame from outside: all serial traffic comes only from accepted commands. They also assume that reset is applied before the first command, so that the busy flag and the chip select begin in agreement. The stimulus issues commands only after polling the busy bits clear, except in the deliberate test of writes made while busy. It drives the flash inputs only from a model that changes them on falling serial clock edges, so the sampled lane values stay stable across each high phase.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    localparam int ADDR_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int REG_AW  = 8;
    localparam int CNT_W   = 6;

    localparam logic [REG_AW-1:0] OFS_CMD    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_RDATA  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_ADR0   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_ADR1   = 8'h09;
    localparam logic [REG_AW-1:0] OFS_ADR2   = 8'h0A;
    localparam logic [REG_AW-1:0] OFS_WDATA  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_OPC_A  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_OPC_B  = 8'h11;
    localparam logic [REG_AW-1:0] OFS_TIMING = 8'h14;
    localparam logic [REG_AW-1:0] OFS_MODE   = 8'h18;
    localparam logic [REG_AW-1:0] OFS_ADR3   = 8'h1C;

    localparam logic [BYTE_W-1:0] CMD_BYTE_RD = 8'h81;
    localparam logic [BYTE_W-1:0] CMD_BYTE_WR = 8'h90;
    localparam int BUSY_RD_BIT = 0;
    localparam int BUSY_WR_BIT = 4;

    localparam int MB_DUAL_DATA = 0;
    localparam int MB_DUAL_ADDR = 1;
    localparam int MB_QUAD_DATA = 2;
    localparam int MB_QUAD_ADDR = 3;
    localparam int MB_WIDE_ADDR = 4;
    localparam int TB_DUMMY_EN  = 0;

    typedef enum logic [1:0] {
        LN_X1 = 2'd0,
        LN_X2 = 2'd1,
        LN_X4 = 2'd2
    } lanes_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic               is_write;
        logic [BYTE_W-1:0]  opcode;
        logic [ADDR_W-1:0]  addr;
        logic               four_byte;
        lanes_e             addr_ln;
        lanes_e             data_ln;
        logic               dummy;
        logic [BYTE_W-1:0]  wbyte;
    } job_t;

    function automatic int unsigned ln_count(lanes_e l);
        case (l)
            LN_X2:   return 2;
            LN_X4:   return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [LANES-1:0] ln_mask(lanes_e l);
        case (l)
            LN_X2:   return 4'b0011;
            LN_X4:   return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clocks_for(int unsigned nbits, lanes_e l);
        return CNT_W'(nbits / ln_count(l) - 1);
    endfunction

endpackage

// File: rtl/sfl_regs.sv
module sfl_regs
    import sfl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              busy,
    output logic              start,
    output logic              start_write,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] timing_q,
    output logic [BYTE_W-1:0] opc_a_q,
    output logic [BYTE_W-1:0] opc_b_q,
    output logic [BYTE_W-1:0] wdata_q
);

    logic              busy_rd, busy_wr;
    logic [BYTE_W-1:0] rdata_q;
    logic              accept, cmd_rd, cmd_wr;

    assign busy        = busy_rd | busy_wr;
    assign accept      = reg_we && !busy;
    assign cmd_rd      = accept && (reg_addr == OFS_CMD) && (reg_wdata == CMD_BYTE_RD);
    assign cmd_wr      = accept && (reg_addr == OFS_CMD) && (reg_wdata == CMD_BYTE_WR);
    assign start       = cmd_rd | cmd_wr;
    assign start_write = cmd_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_rd  <= 1'b0;
            busy_wr  <= 1'b0;
            rdata_q  <= '0;
            addr_q   <= '0;
            mode_q   <= '0;
            timing_q <= '0;
            opc_a_q  <= '0;
            opc_b_q  <= '0;
            wdata_q  <= '0;
        end else begin
            if (done) begin
                if (busy_rd) rdata_q <= rx_byte;
                addr_q  <= addr_q + 32'd1;
                busy_rd <= 1'b0;
                busy_wr <= 1'b0;
            end
            if (cmd_rd) busy_rd <= 1'b1;
            if (cmd_wr) busy_wr <= 1'b1;
            if (accept) begin
                case (reg_addr)
                    OFS_ADR0:   addr_q[7:0]   <= reg_wdata;
                    OFS_ADR1:   addr_q[15:8]  <= reg_wdata;
                    OFS_ADR2:   addr_q[23:16] <= reg_wdata;
                    OFS_ADR3:   addr_q[31:24] <= reg_wdata;
                    OFS_WDATA:  wdata_q       <= reg_wdata;
                    OFS_OPC_A:  opc_a_q       <= reg_wdata;
                    OFS_OPC_B:  opc_b_q       <= reg_wdata;
                    OFS_TIMING: timing_q      <= reg_wdata;
                    OFS_MODE:   mode_q        <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD: begin
                reg_rdata[BUSY_RD_BIT] = busy_rd;
                reg_rdata[BUSY_WR_BIT] = busy_wr;
            end
            OFS_RDATA:  reg_rdata = rdata_q;
            OFS_ADR0:   reg_rdata = addr_q[7:0];
            OFS_ADR1:   reg_rdata = addr_q[15:8];
            OFS_ADR2:   reg_rdata = addr_q[23:16];
            OFS_ADR3:   reg_rdata = addr_q[31:24];
            OFS_WDATA:  reg_rdata = wdata_q;
            OFS_OPC_A:  reg_rdata = opc_a_q;
            OFS_OPC_B:  reg_rdata = opc_b_q;
            OFS_TIMING: reg_rdata = timing_q;
            OFS_MODE:   reg_rdata = mode_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sfl_jobfmt.sv
module sfl_jobfmt
    import sfl_pkg::*;
#(
    parameter logic [7:0] WR_OPCODE = 8'h02
) (
    input  logic              start_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] mode,
    input  logic [BYTE_W-1:0] timing,
    input  logic [BYTE_W-1:0] opc_a,
    input  logic [BYTE_W-1:0] opc_b,
    input  logic [BYTE_W-1:0] wdata,
    output job_t              job
);

    lanes_e rd_addr_ln, rd_data_ln;

    always_comb begin
        if (mode[MB_QUAD_ADDR])      rd_addr_ln = LN_X4;
        else if (mode[MB_DUAL_ADDR]) rd_addr_ln = LN_X2;
        else                         rd_addr_ln = LN_X1;

        if (mode[MB_QUAD_DATA])      rd_data_ln = LN_X4;
        else if (mode[MB_DUAL_DATA]) rd_data_ln = LN_X2;
        else                         rd_data_ln = LN_X1;
    end

    always_comb begin
        job.is_write  = start_write;
        job.addr      = addr;
        job.four_byte = mode[MB_WIDE_ADDR];
        job.wbyte     = wdata;
        if (start_write) begin
            job.opcode  = WR_OPCODE;
            job.addr_ln = LN_X1;
            job.data_ln = LN_X1;
            job.dummy   = 1'b0;
        end else begin
            job.opcode  = mode[MB_QUAD_DATA] ? opc_b : opc_a;
            job.addr_ln = rd_addr_ln;
            job.data_ln = rd_data_ln;
            job.dummy   = timing[TB_DUMMY_EN];
        end
    end

endmodule

// File: rtl/sfl_engine.sv
module sfl_engine
    import sfl_pkg::*;
#(
    parameter int DUMMY_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_t              job,
    input  logic [LANES-1:0]  io_in,
    output logic              sclk,
    output logic              cs_n,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int NARROW_BITS = ADDR_W - BYTE_W;

    phase_e            phase;
    logic              half;
    logic [CNT_W-1:0]  left;
    logic [ADDR_W-1:0] tx;
    logic [BYTE_W-1:0] rx;
    job_t              jq;
    logic              done_q;

    lanes_e            cur_ln;
    logic [ADDR_W-1:0] tx_shift;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        case (phase)
            PH_ADDR: cur_ln = jq.addr_ln;
            PH_DATA: cur_ln = jq.data_ln;
            default: cur_ln = LN_X1;
        endcase
    end

    always_comb begin
        case (cur_ln)
            LN_X2: begin
                io_out   = {2'b00, tx[ADDR_W-1:ADDR_W-2]};
                tx_shift = {tx[ADDR_W-3:0], 2'b00};
                rx_next  = {rx[BYTE_W-3:0], io_in[1:0]};
            end
            LN_X4: begin
                io_out   = tx[ADDR_W-1:ADDR_W-4];
                tx_shift = {tx[ADDR_W-5:0], 4'b0000};
                rx_next  = {rx[BYTE_W-5:0], io_in};
            end
            default: begin
                io_out   = {3'b000, tx[ADDR_W-1]};
                tx_shift = {tx[ADDR_W-2:0], 1'b0};
                rx_next  = {rx[BYTE_W-2:0], io_in[1]};
            end
        endcase
    end

    always_comb begin
        case (phase)
            PH_OPC:  io_oe = ln_mask(LN_X1);
            PH_ADDR: io_oe = ln_mask(jq.addr_ln);
            PH_DATA: io_oe = jq.is_write ? ln_mask(LN_X1) : '0;
            default: io_oe = '0;
        endcase
    end

    assign sclk    = half;
    assign cs_n    = (phase == PH_IDLE);
    assign done    = done_q;
    assign rx_byte = rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            half   <= 1'b0;
            left   <= '0;
            tx     <= '0;
            rx     <= '0;
            jq     <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    jq    <= job;
                    phase <= PH_OPC;
                    tx    <= {job.opcode, {NARROW_BITS{1'b0}}};
                    left  <= clocks_for(BYTE_W, LN_X1);
                    half  <= 1'b0;
                end
            end else if (!half) begin
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                tx   <= tx_shift;
                if (phase == PH_DATA && !jq.is_write) rx <= rx_next;
                if (left != '0) begin
                    left <= left - 1'b1;
                end else begin
                    case (phase)
                        PH_OPC: begin
                            phase <= PH_ADDR;
                            if (jq.four_byte) begin
                                tx   <= jq.addr;
                                left <= clocks_for(ADDR_W, jq.addr_ln);
                            end else begin
                                tx   <= {jq.addr[NARROW_BITS-1:0], {BYTE_W{1'b0}}};
                                left <= clocks_for(NARROW_BITS, jq.addr_ln);
                            end
                        end
                        PH_ADDR: begin
                            if (jq.dummy) begin
                                phase <= PH_DUMMY;
                                left  <= CNT_W'(DUMMY_CLKS - 1);
                            end else begin
                                phase <= PH_DATA;
                                tx    <= {jq.wbyte, {NARROW_BITS{1'b0}}};
                                left  <= clocks_for(BYTE_W, jq.data_ln);
                            end
                        end
                        PH_DUMMY: begin
                            phase <= PH_DATA;
                            tx    <= {jq.wbyte, {NARROW_BITS{1'b0}}};
                            left  <= clocks_for(BYTE_W, jq.data_ln);
                        end
                        default: begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/sfl_byte_seq.sv
module sfl_byte_seq
    import sfl_pkg::*;
#(
    parameter logic [7:0] WR_OPCODE  = 8'h02,
    parameter int         DUMMY_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic [LANES-1:0]  spi_io_out,
    output logic [LANES-1:0]  spi_io_oe,
    input  logic [LANES-1:0]  spi_io_in
);

    logic              busy, start, start_write, done;
    logic [BYTE_W-1:0] rx_byte;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] mode_q, timing_q, opc_a_q, opc_b_q, wdata_q;
    job_t              job;

    sfl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .done        (done),
        .rx_byte     (rx_byte),
        .busy        (busy),
        .start       (start),
        .start_write (start_write),
        .addr_q      (addr_q),
        .mode_q      (mode_q),
        .timing_q    (timing_q),
        .opc_a_q     (opc_a_q),
        .opc_b_q     (opc_b_q),
        .wdata_q     (wdata_q)
    );

    sfl_jobfmt #(.WR_OPCODE(WR_OPCODE)) u_fmt (
        .start_write (start_write),
        .addr        (addr_q),
        .mode        (mode_q),
        .timing      (timing_q),
        .opc_a       (opc_a_q),
        .opc_b       (opc_b_q),
        .wdata       (wdata_q),
        .job         (job)
    );

    sfl_engine #(.DUMMY_CLKS(DUMMY_CLKS)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .job     (job),
        .io_in   (spi_io_in),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .io_out  (spi_io_out),
        .io_oe   (spi_io_oe),
        .done    (done),
        .rx_byte (rx_byte)
    );

endmodule

// File: rtl/sfl_byte_seq_chk.sv
module sfl_byte_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        sclk,
    input logic [3:0]  io_out,
    input logic [3:0]  io_oe,
    input logic        busy,
    input logic        done,
    input logic [31:0] addr_q
);

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && io_oe == 4'b0000))
        else $error("R1: pins active while deselected");

    p_frame_busy_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy)
        else $error("R3: frame running without busy");

    p_done_clears_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy)
        else $error("R3: busy not cleared after completion");

    p_addr_step_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (addr_q == $past(addr_q) + 32'd1))
        else $error("R10: address did not advance by one");

    p_sclk_toggle_r12: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n)) |-> (sclk != $past(sclk)))
        else $error("R12: serial clock stalled inside a frame");

    p_out_hold_r12: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(io_out))
        else $error("R12: lane output changed while clock high");

endmodule

bind sfl_byte_seq sfl_byte_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (spi_cs_n),
    .sclk   (spi_sclk),
    .io_out (spi_io_out),
    .io_oe  (spi_io_oe),
    .busy   (busy),
    .done   (done),
    .addr_q (addr_q)
);

// File: tb/sfl_byte_seq_tb.sv
module sfl_byte_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n;
    logic [3:0] spi_io_out, spi_io_oe, spi_io_in;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    int         rise_cnt = 0;
    int         fall_cnt = 0;
    int         frames   = 0;
    logic [3:0] out_rec [64];
    logic [3:0] oe_rec  [64];
    logic [7:0] resp_byte  = 8'h00;
    int         resp_lanes = 1;
    int         data_start = 1000;

    always #4 clk = ~clk;

    sfl_byte_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_io_out (spi_io_out),
        .spi_io_oe  (spi_io_oe),
        .spi_io_in  (spi_io_in)
    );

    function automatic logic [3:0] resp_nib(int k, int ds, int l, logic [7:0] b);
        int j;
        if (k < ds) return 4'b0101;
        j = k - ds;
        if (j >= 8 / l) return 4'b0000;
        if (l == 1) return {2'b10, b[7-j], 1'b1};
        if (l == 2) return {2'b10, b[7-2*j], b[6-2*j]};
        return (j == 0) ? b[7:4] : b[3:0];
    endfunction

    assign spi_io_in = resp_nib(fall_cnt, data_start, resp_lanes, resp_byte);

    always @(negedge spi_cs_n) begin
        rise_cnt = 0;
        fall_cnt = 0;
        frames   = frames + 1;
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL R12 clock edge outside frame: actual cs_n=%0b expected 0", spi_cs_n);
        end
        if (rise_cnt < 64) begin
            out_rec[rise_cnt] = spi_io_out;
            oe_rec[rise_cnt]  = spi_io_oe;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge spi_sclk) fall_cnt = fall_cnt + 1;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_addr(output logic [31:0] a);
        logic [7:0] b0, b1, b2, b3;
        reg_rd(8'h08, b0); reg_rd(8'h09, b1); reg_rd(8'h0A, b2); reg_rd(8'h1C, b3);
        a = {b3, b2, b1, b0};
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int guard = 0;
        do begin
            reg_rd(8'h00, v);
            guard++;
        end while (v != 8'h00 && guard < 2000);
        if (v != 8'h00) chk("R3", "busy never cleared", {24'h0, v}, 32'h0);
    endtask

    task automatic set_addr(input logic [31:0] a);
        reg_wr(8'h08, a[7:0]); reg_wr(8'h09, a[15:8]);
        reg_wr(8'h0A, a[23:16]); reg_wr(8'h1C, a[31:24]);
    endtask

    task automatic run_read(input logic [7:0] mode, input bit fast, input bit load_addr,
                            input logic [31:0] a, input logic [7:0] oa, input logic [7:0] ob,
                            input logic [7:0] b);
        int dl, al, nb, dm, ds, nclk, f0;
        logic [31:0] got, expa, after;
        logic [7:0] op, v;
        bit oe_ok;
        if (load_addr) set_addr(a);
        reg_wr(8'h18, mode);
        reg_wr(8'h14, {7'b0, fast});
        reg_wr(8'h10, oa);
        reg_wr(8'h11, ob);
        dl = mode[2] ? 4 : (mode[0] ? 2 : 1);
        al = mode[3] ? 4 : (mode[1] ? 2 : 1);
        nb = mode[4] ? 4 : 3;
        dm = fast ? 8 : 0;
        ds = 8 + nb * 8 / al + dm;
        nclk = ds + 8 / dl;
        resp_byte = b; resp_lanes = dl; data_start = ds;
        f0 = frames;
        reg_wr(8'h00, 8'h81);
        reg_rd(8'h00, v);
        chk("R3", "read busy bit 0", {24'h0, v}, 32'h01);
        wait_idle();
        chk("R3", "one frame per read", frames - f0, 1);
        chk("R7", "read clock count", rise_cnt, nclk);
        op = '0; oe_ok = 1;
        for (int k = 0; k < 8; k++) begin
            op = {op[6:0], out_rec[k][0]};
            if (oe_rec[k] != 4'b0001) oe_ok = 0;
        end
        chk("R4", "read opcode", op, mode[2] ? ob : oa);
        chk("R4", "opcode lane enable", oe_ok, 1);
        got = '0; oe_ok = 1;
        for (int j = 0; j < nb * 8 / al; j++) begin
            for (int l = al - 1; l >= 0; l--) got = {got[30:0], out_rec[8+j][l]};
            if (oe_rec[8+j] != ((al == 4) ? 4'b1111 : (al == 2) ? 4'b0011 : 4'b0001)) oe_ok = 0;
        end
        expa = (nb == 4) ? a : {8'h00, a[23:0]};
        chk("R5", "address sent", got, expa);
        chk("R6", "address lane enables", oe_ok, 1);
        oe_ok = 1;
        for (int k = 8 + nb * 8 / al; k < nclk; k++) if (oe_rec[k] != 4'b0000) oe_ok = 0;
        chk("R7", "dummy and data lanes released", oe_ok, 1);
        reg_rd(8'h04, v);
        chk("R8", "captured byte", {24'h0, v}, {24'h0, b});
        rd_addr(after);
        chk("R10", "address advanced", after, a + 32'd1);
    endtask

    task automatic run_write(input logic [7:0] mode, input logic [31:0] a, input logic [7:0] w);
        int nb, nclk;
        logic [31:0] got, expa, after;
        logic [7:0] op, v;
        bit oe_ok;
        set_addr(a);
        reg_wr(8'h18, mode);
        reg_wr(8'h14, 8'h01);
        reg_wr(8'h0C, w);
        nb = mode[4] ? 4 : 3;
        nclk = 8 + nb * 8 + 8;
        data_start = 1000;
        reg_wr(8'h00, 8'h90);
        reg_rd(8'h00, v);
        chk("R3", "write busy bit 4", {24'h0, v}, 32'h10);
        wait_idle();
        chk("R7", "write clock count without dummies", rise_cnt, nclk);
        op = '0; got = '0; oe_ok = 1;
        for (int k = 0; k < nclk; k++) if (oe_rec[k] != 4'b0001) oe_ok = 0;
        for (int k = 0; k < 8; k++) op = {op[6:0], out_rec[k][0]};
        for (int k = 8; k < 8 + nb * 8; k++) got = {got[30:0], out_rec[k][0]};
        chk("R4", "write opcode", op, 8'h02);
        expa = (nb == 4) ? a : {8'h00, a[23:0]};
        chk("R6", "write address on single lane", got, expa);
        chk("R6", "write lane enables", oe_ok, 1);
        op = '0;
        for (int k = 8 + nb * 8; k < nclk; k++) op = {op[6:0], out_rec[k][0]};
        chk("R9", "write data byte", op, w);
        rd_addr(after);
        chk("R10", "address advanced after write", after, a + 32'd1);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [31:0] a;
        logic [7:0]  ofs [11];
        int f0;
        ofs = '{8'h00, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0C, 8'h10, 8'h11, 8'h14, 8'h18, 8'h1C};
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", "cs_n after reset", spi_cs_n, 1);
        chk("R1", "sclk after reset", spi_sclk, 0);
        chk("R1", "oe after reset", spi_io_oe, 0);
        for (int i = 0; i < 11; i++) begin
            reg_rd(ofs[i], v);
            chk("R1", "register after reset", {24'h0, v}, 32'h0);
        end

        // R2 register readback
        for (int i = 2; i < 11; i++) reg_wr(ofs[i], 8'h3C + 8'(i * 17));
        for (int i = 2; i < 11; i++) begin
            reg_rd(ofs[i], v);
            chk("R2", "register readback", {24'h0, v}, {24'h0, 8'h3C + 8'(i * 17)});
        end

        // R3 unknown command ignored
        f0 = frames;
        reg_wr(8'h00, 8'h55);
        repeat (20) @(negedge clk);
        reg_rd(8'h00, v);
        chk("R3", "unknown command busy", {24'h0, v}, 32'h0);
        chk("R3", "unknown command no frame", frames - f0, 0);

        // R4..R8, R10 sweep over data lanes, address lanes, dummy, address width
        for (int ri = 0; ri < 4; ri++)
            for (int ai = 0; ai < 4; ai++)
                for (int fi = 0; fi < 2; fi++)
                    for (int wi = 0; wi < 2; wi++) begin
                        int idx;
                        logic [7:0] rb, abits;
                        idx = ((ri * 4 + ai) * 2 + fi) * 2 + wi;
                        rb = (ri == 0) ? 8'h00 : (ri == 1) ? 8'h01 : (ri == 2) ? 8'h04 : 8'h05;
                        abits = (ai == 0) ? 8'h00 : (ai == 1) ? 8'h02 : (ai == 2) ? 8'h08 : 8'h0A;
                        run_read(rb | abits | (wi != 0 ? 8'h10 : 8'h00), fi != 0, 1'b1,
                                 32'h1234_5678 ^ (32'(idx) * 32'h0101_0113),
                                 8'h0B + 8'(idx), 8'h6B + 8'(idx), 8'(idx * 37 + 5));
                    end

        // R10 consecutive read uses incremented address, and wrap
        set_addr(32'h00AB_CDEF);
        run_read(8'h10, 1'b1, 1'b0, 32'h00AB_CDEF, 8'h0B, 8'hEB, 8'hC3);
        run_read(8'h10, 1'b1, 1'b0, 32'h00AB_CDF0, 8'h0B, 8'hEB, 8'h3C);
        run_read(8'h00, 1'b0, 1'b1, 32'hFFFF_FFFF, 8'h03, 8'h6B, 8'h96);

        // R9 writes with mode bits that must not affect write lanes
        run_write(8'h0F, 32'h0000_1000, 8'hA5);
        run_write(8'h1F, 32'h89AB_CDEF, 8'h5A);
        run_write(8'h00, 32'h00FF_FFFF, 8'h81);
        run_write(8'h10, 32'hFFFF_FFFF, 8'h00);

        // R11 writes while busy ignored
        set_addr(32'h0000_0040);
        reg_wr(8'h18, 8'h00);
        reg_wr(8'h14, 8'h00);
        reg_wr(8'h10, 8'h03);
        resp_byte = 8'h77; resp_lanes = 1; data_start = 32;
        f0 = frames;
        reg_wr(8'h00, 8'h81);
        reg_wr(8'h08, 8'hEE);
        reg_wr(8'h18, 8'h1F);
        reg_wr(8'h00, 8'h90);
        wait_idle();
        repeat (30) @(negedge clk);
        reg_rd(8'h08, v);
        chk("R11", "address write while busy", {24'h0, v}, 32'h41);
        reg_rd(8'h18, v);
        chk("R11", "mode write while busy", {24'h0, v}, 32'h0);
        chk("R11", "command while busy", frames - f0, 1);
        reg_rd(8'h04, v);
        chk("R8", "single lane byte", {24'h0, v}, 32'h77);
        chk("R12", "cs_n high after frame", spi_cs_n, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule